// File: doc/BRIEF.md
# CPU System Register Bank

This block holds the control and status registers that sit beside a CPU core: the save pairs for maskable interrupts, non-maskable interrupts, table calls and debug traps, the exception cause word, the program status word and the table-call base pointer. Software reaches each register through a 5-bit register number. A load-to-system-register port writes it, and a store-from-system-register port reads it. Numbers that name no register read as zero and discard writes. The cause word cannot be written by software. The debug-trap pair can be reached only while the core is in its debug-trap state.

The core also drives three hardware capture strobes. On interrupt, NMI or debug-trap entry, a strobe loads the current PC and PSW into the matching save pair. For interrupt and NMI entry it also records the supplied code in one half of the cause word. When a capture and a software write hit the same register in the same cycle, the capture wins. There is only one interrupt save set, so a second capture replaces the first. Software that nests interrupts must save the pair itself. The block outputs the saved return PCs for the interrupt, NMI and table-call pairs with bit 0 forced low, so a return always lands on an even address.

All ports are plain control and data pins with no handshake. A read never stalls and is answered in the cycle it is asked. A write or capture is accepted on every cycle it is presented.

Top module: `sysreg_bank`

## Requirements
- R1: After synchronous active-high reset, every register reads 0, including the debug pair when read in debug mode. All four return-PC outputs are 0.
- R2: Register numbers map as follows: 0 interrupt PC save, 1 interrupt PSW save, 2 NMI PC save, 3 NMI PSW save, 4 cause, 5 PSW, 16 table-call PC save, 17 table-call PSW save, 18 debug PC save, 19 debug PSW save, 20 table-call base. A value written to any writable number reads back unchanged, all 32 bits including bit 0.
- R3: Numbers 6 to 15 and 21 to 31 are reserved. A write to a reserved number changes no register. A read from a reserved number returns 0.
- R4: A software write to number 4 (cause) is ignored.
- R5: Numbers 18 and 19 read 0 and ignore writes while `dbg_mode` is 0. While `dbg_mode` is 1 they read and write normally.
- R6: `irq_ret_pc`, `nmi_ret_pc` and `call_ret_pc` equal registers 0, 2 and 16 with bit 0 cleared. `dbg_ret_pc` equals register 18 unmodified.
- R7: When `irq_take` is 1, the next edge loads `cap_pc` into register 0, `cap_psw` into register 1 and `irq_code` into cause bits 15:0. Cause bits 31:16 are left unchanged.
- R8: When `nmi_take` is 1, the next edge loads `cap_pc` into register 2, `cap_psw` into register 3 and `nmi_code` into cause bits 31:16. Cause bits 15:0 are left unchanged.
- R9: A second interrupt capture overwrites registers 0 and 1 and cause bits 15:0 with the new values.
- R10: When a capture and a software write target the same register in the same cycle, the register takes the captured value.
- R11: When `dbg_take` is 1, the next edge loads `cap_pc` and `cap_psw` into registers 18 and 19, whatever the value of `dbg_mode`.
- R12: `sw_rdata` reflects the register addressed by `sw_rnum` in the same cycle. A write becomes readable from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode | input | 1 | Core is in the debug-trap state |
| sw_we | input | 1 | Software write strobe |
| sw_wnum | input | 5 | Register number to write |
| sw_wdata | input | 32 | Write data |
| sw_rnum | input | 5 | Register number to read |
| sw_rdata | output | 32 | Read data, combinational |
| irq_take | input | 1 | Maskable interrupt entry capture |
| nmi_take | input | 1 | NMI entry capture |
| dbg_take | input | 1 | Debug-trap entry capture |
| cap_pc | input | 32 | PC to capture |
| cap_psw | input | 32 | PSW to capture |
| irq_code | input | 16 | Interrupt/exception code |
| nmi_code | input | 16 | NMI code |
| irq_ret_pc | output | 32 | Interrupt return PC, bit 0 low |
| nmi_ret_pc | output | 32 | NMI return PC, bit 0 low |
| call_ret_pc | output | 32 | Table-call return PC, bit 0 low |
| dbg_ret_pc | output | 32 | Debug-trap return PC |

## Verification
The assertions check the following on every cycle:
- reserved and locked debug numbers read as zero;
- the cause word does not move under a software write;
- a capture always beats a software write;
- each capture lands its code in the right half of the cause word;
- the return PC follows a software write with bit 0 cleared;
- a write select is never aimed at two registers at once.

Only the bench scenarios can show certain other behaviours. These are the exact mapping of every register number to its own storage, and that reserved writes leave every other register untouched. They also include the ordering across a sequence: that a locked debug write stays lost after debug mode returns, and that a second interrupt replaces the first while keeping the NMI half.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_W  = 5;
  localparam int CODE_W = DATA_W / 2;
  localparam int SLOTS  = 11;
  localparam int PAIRS  = 4;

  typedef enum logic [3:0] {
    SL_IPC   = 4'd0,
    SL_IPSW  = 4'd1,
    SL_NPC   = 4'd2,
    SL_NPSW  = 4'd3,
    SL_CAUSE = 4'd4,
    SL_PSW   = 4'd5,
    SL_TPC   = 4'd6,
    SL_TPSW  = 4'd7,
    SL_DPC   = 4'd8,
    SL_DPSW  = 4'd9,
    SL_TBASE = 4'd10
  } slot_e;

  // Register number to one-hot storage slot; all zero for reserved numbers.
  function automatic logic [SLOTS-1:0] slot_vec(input logic [NUM_W-1:0] n);
    logic [SLOTS-1:0] v;
    v = '0;
    case (n)
      5'd0:  v[SL_IPC]   = 1'b1;
      5'd1:  v[SL_IPSW]  = 1'b1;
      5'd2:  v[SL_NPC]   = 1'b1;
      5'd3:  v[SL_NPSW]  = 1'b1;
      5'd4:  v[SL_CAUSE] = 1'b1;
      5'd5:  v[SL_PSW]   = 1'b1;
      5'd16: v[SL_TPC]   = 1'b1;
      5'd17: v[SL_TPSW]  = 1'b1;
      5'd18: v[SL_DPC]   = 1'b1;
      5'd19: v[SL_DPSW]  = 1'b1;
      5'd20: v[SL_TBASE] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  // Save pair p: its PC slot; the PSW slot follows directly.
  function automatic int pair_pc_slot(input int p);
    return (p < 2) ? 2 * p : 6 + 2 * (p - 2);
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter bit IS_WRITE = 1'b0
) (
  input  logic [NUM_W-1:0] num,
  input  logic             en,
  input  logic             dbg_mode,
  output logic [SLOTS-1:0] sel
);
  logic [SLOTS-1:0] hit;
  logic [SLOTS-1:0] lock;

  assign hit = slot_vec(num);

  generate
    if (IS_WRITE) begin : g_wr
      always_comb begin
        lock = '0;
        lock[SL_CAUSE] = 1'b1;
        lock[SL_DPC]   = ~dbg_mode;
        lock[SL_DPSW]  = ~dbg_mode;
      end
    end else begin : g_rd
      always_comb begin
        lock = '0;
        lock[SL_DPC]  = ~dbg_mode;
        lock[SL_DPSW] = ~dbg_mode;
      end
    end
  endgenerate

  assign sel = en ? (hit & ~lock) : '0;

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(sel)); // R2
  end
endmodule

// File: rtl/sysreg_save_pair.sv
module sysreg_save_pair #(
  parameter int W         = 32,
  parameter bit CLEAR_LSB = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_pc_we,
  input  logic         sw_psw_we,
  input  logic [W-1:0] sw_data,
  input  logic         cap,
  input  logic [W-1:0] cap_pc,
  input  logic [W-1:0] cap_psw,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] psw_q,
  output logic [W-1:0] ret_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      psw_q <= '0;
    end else if (cap) begin
      pc_q  <= cap_pc;
      psw_q <= cap_psw;
    end else begin
      if (sw_pc_we)  pc_q  <= sw_data;
      if (sw_psw_we) psw_q <= sw_data;
    end
  end

  generate
    if (CLEAR_LSB) begin : g_even
      assign ret_pc = {pc_q[W-1:1], 1'b0};
      AST_RET_EVEN: assert property (@(posedge clk) disable iff (rst)
        sw_pc_we && !cap |=> ret_pc == {$past(sw_data[W-1:1]), 1'b0}); // R6
    end else begin : g_raw
      assign ret_pc = pc_q;
    end
  endgenerate

  AST_CAP_WINS: assert property (@(posedge clk) disable iff (rst)
    cap |=> (pc_q == $past(cap_pc)) && (psw_q == $past(cap_psw))); // R10
  AST_SW_STORE: assert property (@(posedge clk) disable iff (rst)
    sw_psw_we && !cap |=> psw_q == $past(sw_data)); // R12
endmodule

// File: rtl/sysreg_cause.sv
module sysreg_cause #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           irq_take,
  input  logic [W/2-1:0] irq_code,
  input  logic           nmi_take,
  input  logic [W/2-1:0] nmi_code,
  output logic [W-1:0]   cause_q
);
  localparam int HW = W / 2;

  logic [1:0]        take;
  logic [1:0][HW-1:0] code;
  assign take = {nmi_take, irq_take};
  assign code = {nmi_code, irq_code};

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HW-1:0] half_q;
      always_ff @(posedge clk) begin
        if (rst)          half_q <= '0;
        else if (take[h]) half_q <= code[h];
      end
      assign cause_q[h*HW +: HW] = half_q;
    end
  endgenerate

  AST_IRQ_CODE: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> cause_q[HW-1:0] == $past(irq_code)); // R7
  AST_IRQ_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    irq_take && !nmi_take |=> $stable(cause_q[W-1:HW])); // R7
  AST_NMI_CODE: assert property (@(posedge clk) disable iff (rst)
    nmi_take |=> cause_q[W-1:HW] == $past(nmi_code)); // R8
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int XLEN = DATA_W,
  parameter int NW   = NUM_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dbg_mode,
  input  logic            sw_we,
  input  logic [NW-1:0]   sw_wnum,
  input  logic [XLEN-1:0] sw_wdata,
  input  logic [NW-1:0]   sw_rnum,
  output logic [XLEN-1:0] sw_rdata,
  input  logic            irq_take,
  input  logic            nmi_take,
  input  logic            dbg_take,
  input  logic [XLEN-1:0] cap_pc,
  input  logic [XLEN-1:0] cap_psw,
  input  logic [XLEN/2-1:0] irq_code,
  input  logic [XLEN/2-1:0] nmi_code,
  output logic [XLEN-1:0] irq_ret_pc,
  output logic [XLEN-1:0] nmi_ret_pc,
  output logic [XLEN-1:0] call_ret_pc,
  output logic [XLEN-1:0] dbg_ret_pc
);
  logic [SLOTS-1:0]           wsel;
  logic [SLOTS-1:0]           rsel;
  logic [SLOTS-1:0][XLEN-1:0] slot_q;
  logic [PAIRS-1:0]           pair_cap;
  logic [PAIRS-1:0][XLEN-1:0] pair_ret;
  logic [XLEN-1:0]            psw_q;
  logic [XLEN-1:0]            tbase_q;

  sysreg_decode #(.IS_WRITE(1'b1)) u_wdec (
    .num(sw_wnum), .en(sw_we), .dbg_mode(dbg_mode), .sel(wsel)
  );
  sysreg_decode #(.IS_WRITE(1'b0)) u_rdec (
    .num(sw_rnum), .en(1'b1), .dbg_mode(dbg_mode), .sel(rsel)
  );

  // Pair order: interrupt, NMI, table call, debug trap.
  assign pair_cap = {dbg_take, 1'b0, nmi_take, irq_take};

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      localparam int PS = pair_pc_slot(p);
      sysreg_save_pair #(.W(XLEN), .CLEAR_LSB(p != 3)) u_pair (
        .clk(clk), .rst(rst),
        .sw_pc_we(wsel[PS]), .sw_psw_we(wsel[PS+1]), .sw_data(sw_wdata),
        .cap(pair_cap[p]), .cap_pc(cap_pc), .cap_psw(cap_psw),
        .pc_q(slot_q[PS]), .psw_q(slot_q[PS+1]), .ret_pc(pair_ret[p])
      );
    end
  endgenerate

  sysreg_cause #(.W(XLEN)) u_cause (
    .clk(clk), .rst(rst),
    .irq_take(irq_take), .irq_code(irq_code),
    .nmi_take(nmi_take), .nmi_code(nmi_code),
    .cause_q(slot_q[SL_CAUSE])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q   <= '0;
      tbase_q <= '0;
    end else begin
      if (wsel[SL_PSW])   psw_q   <= sw_wdata;
      if (wsel[SL_TBASE]) tbase_q <= sw_wdata;
    end
  end

  assign slot_q[SL_PSW]   = psw_q;
  assign slot_q[SL_TBASE] = tbase_q;

  always_comb begin
    sw_rdata = '0;
    for (int i = 0; i < SLOTS; i++) begin
      sw_rdata = sw_rdata | (slot_q[i] & {XLEN{rsel[i]}});
    end
  end

  assign irq_ret_pc  = pair_ret[0];
  assign nmi_ret_pc  = pair_ret[1];
  assign call_ret_pc = pair_ret[2];
  assign dbg_ret_pc  = pair_ret[3];

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (slot_vec(sw_rnum) == '0) |-> sw_rdata == '0); // R3
  AST_DBG_READ_LOCK: assert property (@(posedge clk) disable iff (rst)
    !dbg_mode && (sw_rnum == 5'd18 || sw_rnum == 5'd19) |-> sw_rdata == '0); // R5
  AST_DBG_WRITE_LOCK: assert property (@(posedge clk) disable iff (rst)
    !dbg_mode && sw_we && sw_wnum == 5'd18 && !dbg_take |=> $stable(dbg_ret_pc)); // R5
  AST_CAUSE_RO: assert property (@(posedge clk) disable iff (rst)
    sw_we && sw_wnum == 5'd4 && !irq_take && !nmi_take |=> $stable(slot_q[SL_CAUSE])); // R4
endmodule

// File: tb/sysreg_bank_test.sv
module sysreg_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_mode = 1'b0;
  logic        sw_we = 1'b0;
  logic [4:0]  sw_wnum = '0;
  logic [31:0] sw_wdata = '0;
  logic [4:0]  sw_rnum = '0;
  logic [31:0] sw_rdata;
  logic        irq_take = 1'b0, nmi_take = 1'b0, dbg_take = 1'b0;
  logic [31:0] cap_pc = '0, cap_psw = '0;
  logic [15:0] irq_code = '0, nmi_code = '0;
  logic [31:0] irq_ret_pc, nmi_ret_pc, call_ret_pc, dbg_ret_pc;

  sysreg_bank uut (
    .clk(clk), .rst(rst), .dbg_mode(dbg_mode),
    .sw_we(sw_we), .sw_wnum(sw_wnum), .sw_wdata(sw_wdata),
    .sw_rnum(sw_rnum), .sw_rdata(sw_rdata),
    .irq_take(irq_take), .nmi_take(nmi_take), .dbg_take(dbg_take),
    .cap_pc(cap_pc), .cap_psw(cap_psw),
    .irq_code(irq_code), .nmi_code(nmi_code),
    .irq_ret_pc(irq_ret_pc), .nmi_ret_pc(nmi_ret_pc),
    .call_ret_pc(call_ret_pc), .dbg_ret_pc(dbg_ret_pc)
  );

  always #5 clk = ~clk;

  // kind: 0 read data, 1 irq ret, 2 nmi ret, 3 call ret, 4 dbg ret
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  item_t       cur;
  logic [31:0] act;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done     = 1'b0;

  // Monitor: results are compared mid-cycle, away from the active edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      case (cur.kind)
        1: act = irq_ret_pc;
        2: act = nmi_ret_pc;
        3: act = call_ret_pc;
        4: act = dbg_ret_pc;
        default: act = sw_rdata;
      endcase
      n_checks++;
      if (act !== cur.exp) begin
        n_fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", cur.tag, cur.kind, act, cur.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    sw_we = 1'b0; irq_take = 1'b0; nmi_take = 1'b0; dbg_take = 1'b0;
  endtask

  task automatic expect_out(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd(input logic [4:0] n, input logic [31:0] exp, input string tag);
    sw_rnum = n;
    expect_out(0, exp, tag);
    tick();
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    sw_we = 1'b1; sw_wnum = n; sw_wdata = d;
    tick();
  endtask

  task automatic set_cap(input logic [31:0] pc, input logic [31:0] psw);
    cap_pc = pc; cap_psw = psw;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    dbg_mode = 1'b1;

    // R1: reset state
    rd(5'd0, 0, "R1"); rd(5'd1, 0, "R1"); rd(5'd2, 0, "R1"); rd(5'd3, 0, "R1");
    rd(5'd4, 0, "R1"); rd(5'd5, 0, "R1"); rd(5'd16, 0, "R1"); rd(5'd17, 0, "R1");
    rd(5'd18, 0, "R1"); rd(5'd19, 0, "R1"); rd(5'd20, 0, "R1");
    expect_out(1, 0, "R1"); expect_out(2, 0, "R1");
    expect_out(3, 0, "R1"); expect_out(4, 0, "R1");
    tick();

    // R2 / R12: map and round trip; R6: even return PCs
    wr(5'd0, 32'h1234_5679);
    rd(5'd0, 32'h1234_5679, "R12");
    wr(5'd1, 32'hA5A5_0F0F); wr(5'd2, 32'h0000_1001); wr(5'd3, 32'h0000_0033);
    wr(5'd5, 32'h0000_00F5); wr(5'd16, 32'hDEAD_BEEF); wr(5'd17, 32'h0000_0017);
    wr(5'd20, 32'h0000_8000);
    rd(5'd1, 32'hA5A5_0F0F, "R2"); rd(5'd2, 32'h0000_1001, "R2");
    rd(5'd3, 32'h0000_0033, "R2"); rd(5'd5, 32'h0000_00F5, "R2");
    rd(5'd16, 32'hDEAD_BEEF, "R2"); rd(5'd17, 32'h0000_0017, "R2");
    rd(5'd20, 32'h0000_8000, "R2");
    expect_out(1, 32'h1234_5678, "R6"); expect_out(2, 32'h0000_1000, "R6");
    expect_out(3, 32'hDEAD_BEEE, "R6");
    tick();

    // R5: debug pair in and out of debug mode; R6 raw debug return PC
    wr(5'd18, 32'h0000_0021); wr(5'd19, 32'h0000_0077);
    rd(5'd18, 32'h0000_0021, "R5"); rd(5'd19, 32'h0000_0077, "R5");
    expect_out(4, 32'h0000_0021, "R6");
    tick();
    dbg_mode = 1'b0;
    rd(5'd18, 0, "R5"); rd(5'd19, 0, "R5");
    wr(5'd18, 32'h0000_0099); wr(5'd19, 32'h0000_0088);
    dbg_mode = 1'b1;
    rd(5'd18, 32'h0000_0021, "R5"); rd(5'd19, 32'h0000_0077, "R5");

    // R3: reserved numbers
    wr(5'd7, 32'hFFFF_FFFF); wr(5'd21, 32'hFFFF_FFFF); wr(5'd31, 32'hFFFF_FFFF);
    wr(5'd6, 32'hFFFF_FFFF); wr(5'd15, 32'hFFFF_FFFF);
    rd(5'd7, 0, "R3"); rd(5'd31, 0, "R3"); rd(5'd15, 0, "R3");
    rd(5'd5, 32'h0000_00F5, "R3"); rd(5'd20, 32'h0000_8000, "R3");
    rd(5'd0, 32'h1234_5679, "R3"); rd(5'd4, 0, "R3");

    // R4: cause is read-only
    wr(5'd4, 32'hFFFF_FFFF);
    rd(5'd4, 0, "R4");

    // R7: interrupt capture
    set_cap(32'h0000_0100, 32'h0000_0020); irq_code = 16'h0011; irq_take = 1'b1;
    tick();
    rd(5'd0, 32'h0000_0100, "R7"); rd(5'd1, 32'h0000_0020, "R7");
    rd(5'd4, 32'h0000_0011, "R7");

    // R8: NMI capture with odd PC
    set_cap(32'h0000_0203, 32'h0000_0080); nmi_code = 16'h00C0; nmi_take = 1'b1;
    tick();
    rd(5'd2, 32'h0000_0203, "R8"); rd(5'd3, 32'h0000_0080, "R8");
    rd(5'd4, 32'h00C0_0011, "R8");
    expect_out(2, 32'h0000_0202, "R6");
    tick();

    // R9: second interrupt overwrites the single save set
    set_cap(32'h0000_0300, 32'h0000_0001); irq_code = 16'h0022; irq_take = 1'b1;
    tick();
    rd(5'd0, 32'h0000_0300, "R9"); rd(5'd1, 32'h0000_0001, "R9");
    rd(5'd4, 32'h00C0_0022, "R9");

    // R10: capture beats a same-cycle software write
    set_cap(32'h0000_0400, 32'h0000_0005); irq_code = 16'h0033; irq_take = 1'b1;
    sw_we = 1'b1; sw_wnum = 5'd0; sw_wdata = 32'h0000_AAAA;
    tick();
    set_cap(32'h0000_0500, 32'h0000_0006); nmi_code = 16'h0044; nmi_take = 1'b1;
    sw_we = 1'b1; sw_wnum = 5'd3; sw_wdata = 32'h0000_BBBB;
    tick();
    rd(5'd0, 32'h0000_0400, "R10"); rd(5'd3, 32'h0000_0006, "R10");
    rd(5'd4, 32'h0044_0033, "R10");

    // R11: debug capture outside debug mode
    dbg_mode = 1'b0;
    set_cap(32'h0000_0601, 32'h0000_0007); dbg_take = 1'b1;
    tick();
    dbg_mode = 1'b1;
    rd(5'd18, 32'h0000_0601, "R11"); rd(5'd19, 32'h0000_0007, "R11");
    expect_out(4, 32'h0000_0601, "R11");
    tick();

    // R1: reset again clears everything
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    rd(5'd0, 0, "R1"); rd(5'd4, 0, "R1"); rd(5'd18, 0, "R1");

    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule